// File: doc/BRIEF.md
# Channel Activation and Reset Controller

This block keeps an active/standby flag for each channel of a multi-channel voice codec. Host commands arrive as single-cycle strobes with a channel mask. An activate strobe brings the masked channels up. A deactivate strobe or a software-reset strobe puts the masked channels into standby. Only an activate command can bring a channel up.

The block also gathers the device-level reset sources into one registered reset output:
- the asynchronous power-on reset;
- the active-low hardware reset pin;
- an in-band request, made by keeping the serial chip select low while the serial clock rises sixteen times.

When the low-power-mode bit is set and every channel is in standby, the block raises a clock-fail flag. This flag tells the rest of the chip that the reduced-clock condition is in force.

Chip select, serial clock and the hardware reset pin are asynchronous to the system clock. Each passes through a two-stage synchronizer. Command strobes, the mask and the low-power bit are synchronous to the system clock.

Top module: `chan_pwr_ctrl`

## Requirements
- R1: While `por_n` is low, `chan_active` is 0, `dev_reset` is 0 and `clk_fail` is 0.
- R2: While `hw_rst_n` is low, `chan_active` reads 0 and `dev_reset` stays high from the third clock edge on. `dev_reset` falls three edges after `hw_rst_n` returns high.
- R3: With `cmd_activate` high at a clock edge, every channel i with bit i of `cmd_mask` set reads 1 in `chan_active[i]` after that edge. Channels whose mask bit is clear keep their state.
- R4: With `cmd_deactivate` or `cmd_swreset` high at an edge, every masked channel reads 0 after that edge and unmasked channels keep their state. When activate and a standby command share an edge, standby wins for the masked channels.
- R5: No channel turns active at an edge where `cmd_activate` is low. An all-zero mask leaves every channel unchanged.
- R6: If the synchronized `cs_n` stays low while 16 rising edges of `sclk` are seen, `dev_reset` pulses high for exactly one clock cycle and all channels go to standby. The pulse fires once per low period, however many more edges follow.
- R7: Fewer than 16 `sclk` rising edges give no reset. Any return of `cs_n` high clears the edge count, so edges before and after the high period do not add up.
- R8: `clk_fail` is registered as `lp_mode` AND (all channels in standby after the same edge). It clears at the same edge where any channel becomes active, and at the first edge after `lp_mode` drops.
- R9: A reset from any source leaves `lp_mode` untouched, so `clk_fail` rises after the reset once all channels are in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous to clk |
| cs_n | input | 1 | Serial chip select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock, sampled by clk |
| cmd_activate | input | 1 | Activate command strobe |
| cmd_deactivate | input | 1 | Deactivate command strobe |
| cmd_swreset | input | 1 | Software reset command strobe |
| cmd_mask | input | NUM_CH | Channels that a command applies to |
| lp_mode | input | 1 | Low-power mode enable |
| chan_active | output | NUM_CH | Per-channel active flag, 1 = active |
| dev_reset | output | 1 | Registered device reset request |
| clk_fail | output | 1 | Reduced-clock indication |

## Verification
The command path is swept over every starting channel pattern, every mask and each of the three command kinds. It is then swept again with activate and deactivate given at the same edge. Together these sweeps separate set, clear, priority and untouched-channel behaviour.

The chip-select detector gets runs of 15, 16 and 24 serial clock edges, plus 10+10 edges split by a high period. These runs separate the threshold, the single firing and the clearing of the count.

The low-power flag is driven through activation, deactivation and mode toggling. Each hardware reset is checked for the same standby and pulse behaviour.

// File: rtl/chan_pwr_pkg.sv
package chan_pwr_pkg;
    localparam int unsigned DEF_NUM_CH    = 4;
    localparam int unsigned DEF_CS_EDGES  = 16;
    localparam int unsigned SYNC_STAGES   = 2;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_SET   = 2'd1,
        CMD_CLEAR = 2'd2
    } cmd_kind_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int unsigned       WIDTH   = 1,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    import chan_pwr_pkg::*;

    logic [WIDTH-1:0] stage_q [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] stage_d;
            if (s == 0) begin : g_first
                assign stage_d = din;
            end else begin : g_next
                assign stage_d = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d;
            end
        end
    endgenerate

    assign dout = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/cs_hold_detect.sv
module cs_hold_detect #(
    parameter int unsigned EDGES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sclk_s,
    output logic hold_fire
);
    localparam int unsigned CW = $clog2(EDGES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(EDGES);

    typedef struct packed {
        logic          sclk_prev;
        logic [CW-1:0] cnt;
        logic          fire;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        logic rise;
        det_d           = det_q;
        rise            = sclk_s && !det_q.sclk_prev;
        det_d.sclk_prev = sclk_s;
        det_d.fire      = 1'b0;
        if (cs_n_s) begin
            det_d.cnt = '0;
        end else if (rise && det_q.cnt != LIMIT) begin
            det_d.cnt = det_q.cnt + 1'b1;
            if (det_q.cnt + 1'b1 == LIMIT) det_d.fire = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign hold_fire = det_q.fire;

    // R6
    fire_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_q.fire |-> det_q.cnt == LIMIT);
    // R6
    fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_q.fire |=> !det_q.fire);
    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> det_q.cnt == '0);
endmodule

// File: rtl/chan_state_ctrl.sv
module chan_state_ctrl #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req,
    input  logic              act_cmd,
    input  logic              deact_cmd,
    input  logic              swrst_cmd,
    input  logic [NUM_CH-1:0] cmd_mask,
    input  logic              lp_mode,
    output logic [NUM_CH-1:0] act_o,
    output logic              clk_fail_o,
    output logic              dev_reset_o
);
    import chan_pwr_pkg::*;

    typedef struct packed {
        logic [NUM_CH-1:0] act;
        logic              clk_fail;
        logic              dev_rst;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [NUM_CH-1:0] set_m, clr_m;
        cmd_kind_e         kind;
        st_d  = st_q;
        kind  = CMD_NONE;
        if (deact_cmd || swrst_cmd) kind = CMD_CLEAR;
        else if (act_cmd)           kind = CMD_SET;
        set_m = (kind == CMD_SET)   ? cmd_mask : '0;
        clr_m = (kind == CMD_CLEAR) ? cmd_mask : '0;
        if (rst_req) st_d.act = '0;
        else         st_d.act = (st_q.act | set_m) & ~clr_m;
        st_d.clk_fail = lp_mode && (st_d.act == '0);
        st_d.dev_rst  = rst_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o       = st_q.act;
    assign clk_fail_o  = st_q.clk_fail;
    assign dev_reset_o = st_q.dev_rst;

    // R2
    reset_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> st_q.act == '0);
    // R5
    no_spont_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_cmd |=> (st_q.act & ~$past(st_q.act)) == '0);
    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deact_cmd || swrst_cmd) |=> (st_q.act & $past(cmd_mask)) == '0);
    // R8
    clk_fail_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clk_fail |-> st_q.act == '0);
endmodule

// File: rtl/chan_pwr_ctrl.sv
module chan_pwr_ctrl #(
    parameter int unsigned NUM_CH   = chan_pwr_pkg::DEF_NUM_CH,
    parameter int unsigned CS_EDGES = chan_pwr_pkg::DEF_CS_EDGES
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hw_rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              cmd_activate,
    input  logic              cmd_deactivate,
    input  logic              cmd_swreset,
    input  logic [NUM_CH-1:0] cmd_mask,
    input  logic              lp_mode,
    output logic [NUM_CH-1:0] chan_active,
    output logic              dev_reset,
    output logic              clk_fail
);
    logic [2:0] pins_s;
    logic       hold_fire;
    logic       rst_req;

    pwr_sync #(.WIDTH(3), .RST_VAL(3'b011)) i_sync (
        .clk  (clk),
        .rst_n(por_n),
        .din  ({sclk, cs_n, hw_rst_n}),
        .dout (pins_s)
    );

    cs_hold_detect #(.EDGES(CS_EDGES)) i_cs_hold (
        .clk      (clk),
        .rst_n    (por_n),
        .cs_n_s   (pins_s[1]),
        .sclk_s   (pins_s[2]),
        .hold_fire(hold_fire)
    );

    assign rst_req = !pins_s[0] || hold_fire;

    chan_state_ctrl #(.NUM_CH(NUM_CH)) i_state (
        .clk        (clk),
        .rst_n      (por_n),
        .rst_req    (rst_req),
        .act_cmd    (cmd_activate),
        .deact_cmd  (cmd_deactivate),
        .swrst_cmd  (cmd_swreset),
        .cmd_mask   (cmd_mask),
        .lp_mode    (lp_mode),
        .act_o      (chan_active),
        .clk_fail_o (clk_fail),
        .dev_reset_o(dev_reset)
    );

    // R1
    por_quiet_chk: assert property (@(posedge clk)
        !por_n |-> (chan_active == '0 && !dev_reset && !clk_fail));
endmodule

// File: tb/test_chan_pwr_ctrl.sv
module test_chan_pwr_ctrl;
    localparam int NCH = 4;

    logic           clk = 0;
    logic           por_n = 0, hw_rst_n = 1, cs_n = 1, sclk = 0;
    logic           cmd_activate = 0, cmd_deactivate = 0, cmd_swreset = 0;
    logic [NCH-1:0] cmd_mask = '0;
    logic           lp_mode = 0;
    logic [NCH-1:0] chan_active;
    logic           dev_reset, clk_fail;

    int n_chk = 0, n_bad = 0, rst_cycles = 0;

    always #2 clk = ~clk;

    chan_pwr_ctrl i_chan_pwr_ctrl (.*);

    always @(posedge clk) if (dev_reset) rst_cycles <= rst_cycles + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic a, input logic d, input logic s, input logic [NCH-1:0] m);
        @(negedge clk);
        cmd_activate = a; cmd_deactivate = d; cmd_swreset = s; cmd_mask = m;
        @(negedge clk);
        cmd_activate = 0; cmd_deactivate = 0; cmd_swreset = 0; cmd_mask = '0;
    endtask

    task automatic set_state(input logic [NCH-1:0] v);
        cmd(0, 1, 0, '1);
        cmd(1, 0, 0, v);
    endtask

    task automatic sclk_edges(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1; repeat (2) @(negedge clk);
            sclk = 0; repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=1 expected=0");
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        chk("R1 active", chan_active, 0);
        chk("R1 reset", dev_reset, 0);
        chk("R1 clkfail", clk_fail, 0);
        por_n = 1;
        repeat (4) @(negedge clk);

        // R3 R4 R5: sweep of start pattern x mask x command kind
        for (int st = 0; st < 16; st++)
            for (int m = 0; m < 16; m++)
                for (int k = 0; k < 3; k++) begin
                    int e;
                    set_state(NCH'(st));
                    cmd(k == 0, k == 1, k == 2, NCH'(m));
                    e = (k == 0) ? (st | m) : (st & ~m & 15);
                    chk(k == 0 ? "R3 activate" : (m == 0 ? "R5 zero mask" : "R4 standby"),
                        chan_active, e);
                end
        // R4: clear wins over a simultaneous activate
        for (int st = 0; st < 16; st++)
            for (int m = 0; m < 16; m++) begin
                set_state(NCH'(st));
                cmd(1, 1, 0, NCH'(m));
                chk("R4 priority", chan_active, st & ~m & 15);
            end

        // R8 low-power flag
        set_state(0);
        @(negedge clk); lp_mode = 1;
        @(negedge clk);
        chk("R8 lp set", clk_fail, 1);
        @(negedge clk); cmd_activate = 1; cmd_mask = 4'b0100;
        @(negedge clk); cmd_activate = 0; cmd_mask = 0;
        chk("R8 clear on activate", clk_fail, 0);
        chk("R8 active", chan_active, 4'b0100);
        cmd(0, 0, 1, 4'b0100);
        chk("R8 set after swreset", clk_fail, 1);
        @(negedge clk); lp_mode = 0;
        @(negedge clk);
        chk("R8 clear on lp off", clk_fail, 0);

        // R2 hardware reset
        set_state(4'hF);
        lp_mode = 1;
        rst_cycles = 0;
        @(negedge clk); hw_rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R2 not yet", dev_reset, 0);
        @(negedge clk);
        chk("R2 reset high", dev_reset, 1);
        chk("R2 standby", chan_active, 0);
        repeat (5) @(negedge clk);
        chk("R2 held", dev_reset, 1);
        cmd(1, 0, 0, 4'hF);
        chk("R2 activate blocked", chan_active, 0);
        hw_rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R2 still high", dev_reset, 1);
        @(negedge clk);
        chk("R2 released", dev_reset, 0);
        chk("R9 clkfail after reset", clk_fail, 1);
        lp_mode = 0;

        // R7 fewer than 16 edges
        set_state(4'hF);
        repeat (4) @(negedge clk);
        rst_cycles = 0;
        cs_n = 0; sclk_edges(15); repeat (8) @(negedge clk);
        chk("R7 15 edges", rst_cycles, 0);
        chk("R7 channels kept", chan_active, 4'hF);
        cs_n = 1; repeat (8) @(negedge clk);
        // R7 count cleared by cs high
        cs_n = 0; sclk_edges(10);
        cs_n = 1; repeat (4) @(negedge clk);
        cs_n = 0; sclk_edges(10); repeat (8) @(negedge clk);
        chk("R7 split run", rst_cycles, 0);
        cs_n = 1; repeat (8) @(negedge clk);

        // R6 exactly 16 edges
        rst_cycles = 0;
        cs_n = 0; sclk_edges(16); repeat (8) @(negedge clk);
        chk("R6 16 edges one pulse", rst_cycles, 1);
        chk("R6 standby", chan_active, 0);
        cs_n = 1; repeat (8) @(negedge clk);

        // R6 longer run fires once
        set_state(4'h5);
        rst_cycles = 0;
        cs_n = 0; sclk_edges(24); repeat (8) @(negedge clk);
        chk("R6 24 edges one pulse", rst_cycles, 1);
        chk("R6 standby long", chan_active, 0);
        cs_n = 1; repeat (8) @(negedge clk);
        chk("R6 reset low after", dev_reset, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule